// File: doc/BRIEF.md
# Conversion Result Byte-Register View

This block holds the latest 10-bit conversion result and shows it to a bus master as two 8-bit read-only bytes. Byte select 0 is the low byte and byte select 1 is the high byte. A justification control picks where the 10 bits sit across the 16-bit pair. Right justification puts them at the bottom. Left justification puts them at the top, so the high byte alone carries the 8 most significant bits.

A master that needs all 10 bits reads the low byte first and the high byte second. The low-byte read freezes the visible result. Conversions that finish while the result is frozen are parked in a one-entry pending buffer, and a later one replaces an earlier one. The high-byte read releases the freeze, and the parked result becomes visible one cycle later. A master in left-justified mode can read only the high byte. That read never freezes anything, so it never holds up updates.

Read data is combinational from the byte select, the justification control and the visible result. A read strobe acts on the clock edge that ends its cycle.

Top module: `adc_result_regs`

## Requirements
- R1: After reset, both bytes read 0x00 and no freeze is in effect.
- R2: With left_just_i = 0, byte 0 reads result[7:0], and byte 1 reads {6'b0, result[9:8]}.
- R3: With left_just_i = 1, byte 1 reads result[9:2], and byte 0 reads {result[1:0], 6'b0}.
- R4: With no freeze in effect and no low-byte read in the same cycle, a conversion_done pulse makes its result visible from the next cycle.
- R5: After a low-byte read (rd_en_i = 1, rd_addr_i = 0), the visible result does not change until the cycle after a high-byte read.
- R6: High-byte reads (rd_en_i = 1, rd_addr_i = 1) never start a freeze. Conversions keep updating the visible result across them.
- R7: A conversion that finishes during a freeze goes into the pending buffer, and a later one overwrites it. The pending value becomes visible the cycle after the high-byte read. A conversion arriving in the same cycle as that high-byte read wins over the pending value.
- R8: A change of left_just_i changes the read data in the same cycle and leaves the stored result unchanged.
- R9: Writes (wr_en_i = 1 at either address, any data) change neither byte.
- R10: A conversion that finishes in the same cycle as a low-byte read is parked in the pending buffer. That read returns the old result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_done_i | input | 1 | One-cycle pulse: a conversion has finished |
| conv_data_i | input | 10 | Result of the finished conversion |
| left_just_i | input | 1 | 1 = left-justified, 0 = right-justified |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 1 | Byte select: 0 = low byte, 1 = high byte |
| wr_en_i | input | 1 | Write strobe (ignored) |
| wr_addr_i | input | 1 | Write byte select (ignored) |
| wr_data_i | input | 8 | Write data (ignored) |
| rd_data_o | output | 8 | Selected byte |

## Verification
A conversion can finish in the same cycle as either byte read. With a low-byte read, the new result must go to the pending buffer while the read returns the old value. With a high-byte read, the new result must become visible at once and win over any parked one. The bench forces both collisions on purpose, and it also drives random stimulus in which they occur often. A behavioural model that holds a queue of at most one pending result predicts the read data, which is compared on every clock for both justifications.

// File: rtl/adc_res_pkg.sv
package adc_res_pkg;
  typedef enum logic {SEL_LO = 1'b0, SEL_HI = 1'b1} byte_sel_e;
endpackage

// File: rtl/adc_hold_ctrl.sv
module adc_hold_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_lo_i,
  input  logic rd_hi_i,
  output logic hold_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hold_o <= 1'b0;
    else if (rd_hi_i) hold_o <= 1'b0;
    else if (rd_lo_i) hold_o <= 1'b1;
  end
endmodule

// File: rtl/adc_result_store.sv
module adc_result_store #(
  parameter int RES_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             conv_done_i,
  input  logic [RES_W-1:0] conv_data_i,
  input  logic             block_i,
  output logic [RES_W-1:0] vis_o
);
  logic [RES_W-1:0] pend_q;
  logic             pend_v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vis_o    <= '0;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
    end else if (block_i) begin
      if (conv_done_i) begin
        pend_q   <= conv_data_i;
        pend_v_q <= 1'b1;
      end
    end else begin
      // newest result wins over a parked one
      if (conv_done_i)   vis_o <= conv_data_i;
      else if (pend_v_q) vis_o <= pend_q;
      pend_v_q <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_byte_mux.sv
module adc_byte_mux
  import adc_res_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic [RES_W-1:0]  res_i,
  input  logic              left_i,
  input  byte_sel_e         sel_i,
  output logic [BYTE_W-1:0] data_o
);
  localparam int PAIR_W = 2 * BYTE_W;
  localparam int PAD_W  = PAIR_W - RES_W;

  logic [PAIR_W-1:0] pair_r, pair_l, pair;

  assign pair_r = {{PAD_W{1'b0}}, res_i};
  assign pair_l = {res_i, {PAD_W{1'b0}}};
  assign pair   = left_i ? pair_l : pair_r;

  always_comb begin
    if (sel_i == SEL_HI) data_o = pair[PAIR_W-1:BYTE_W];
    else                 data_o = pair[BYTE_W-1:0];
  end
endmodule

// File: rtl/adc_result_regs.sv
module adc_result_regs
  import adc_res_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conv_done_i,
  input  logic [RES_W-1:0]  conv_data_i,
  input  logic              left_just_i,
  input  logic              rd_en_i,
  input  logic              rd_addr_i,
  input  logic              wr_en_i,
  input  logic              wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [BYTE_W-1:0] rd_data_o
);
  byte_sel_e        sel;
  logic             rd_lo, rd_hi, hold_q, block;
  logic [RES_W-1:0] vis;
  logic             unused_wr;

  assign sel       = byte_sel_e'(rd_addr_i);
  assign rd_lo     = rd_en_i && (sel == SEL_LO);
  assign rd_hi     = rd_en_i && (sel == SEL_HI);
  // freeze starts with the low read itself, ends with the high read
  assign block     = rd_lo || (hold_q && !rd_hi);
  assign unused_wr = ^{wr_en_i, wr_addr_i, wr_data_i};

  adc_hold_ctrl u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_lo_i (rd_lo),
    .rd_hi_i (rd_hi),
    .hold_o  (hold_q)
  );

  adc_result_store #(.RES_W(RES_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .conv_done_i (conv_done_i),
    .conv_data_i (conv_data_i),
    .block_i     (block),
    .vis_o       (vis)
  );

  adc_byte_mux #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_mux (
    .res_i  (vis),
    .left_i (left_just_i),
    .sel_i  (sel),
    .data_o (rd_data_o)
  );
endmodule

// File: rtl/adc_result_regs_chk.sv
module adc_result_regs_chk #(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              conv_done_i,
  input logic [RES_W-1:0]  conv_data_i,
  input logic              left_just_i,
  input logic              rd_en_i,
  input logic              rd_addr_i,
  input logic [BYTE_W-1:0] rd_data_o,
  input logic              hold_q,
  input logic [RES_W-1:0]  vis
);
  localparam int PAD_W = 2 * BYTE_W - RES_W;

  assert_right_pad_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!left_just_i && rd_addr_i) |-> rd_data_o[BYTE_W-1:RES_W-BYTE_W] == '0);

  assert_left_pad_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (left_just_i && !rd_addr_i) |-> rd_data_o[PAD_W-1:0] == '0);

  assert_load_free_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_done_i && !hold_q && !(rd_en_i && !rd_addr_i)) |=> vis == $past(conv_data_i));

  assert_frozen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q && !(rd_en_i && rd_addr_i)) |=> $stable(vis));

  assert_hi_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_addr_i) |=> !hold_q);

  assert_lo_collide_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !rd_addr_i) |=> $stable(vis));
endmodule

bind adc_result_regs adc_result_regs_chk #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .conv_done_i (conv_done_i),
  .conv_data_i (conv_data_i),
  .left_just_i (left_just_i),
  .rd_en_i     (rd_en_i),
  .rd_addr_i   (rd_addr_i),
  .rd_data_o   (rd_data_o),
  .hold_q      (hold_q),
  .vis         (vis)
);

// File: tb/tb_adc_result_regs.sv
module tb_adc_result_regs;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       conv_done_i = 1'b0;
  logic [9:0] conv_data_i = '0;
  logic       left_just_i = 1'b0;
  logic       rd_en_i = 1'b0;
  logic       rd_addr_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic       wr_addr_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // behavioural model
  int m_vis = 0;
  int m_pend[$];
  bit m_hold = 0;

  always #5 clk_i = ~clk_i;

  adc_result_regs dut (.*);

  function automatic int exp_byte(int v, bit lj, bit hi);
    if (!lj) return hi ? v / 256 : v % 256;
    return hi ? v / 4 : (v % 4) * 64;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: rd_data actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare, then advance model at posedge
  task automatic step(string tag, bit cd, int cv, bit rd, bit a, bit lj, bit we = 0);
    bit blk;
    conv_done_i = cd; conv_data_i = 10'(cv);
    rd_en_i = rd; rd_addr_i = a; left_just_i = lj;
    wr_en_i = we; wr_addr_i = a; wr_data_i = we ? 8'hff : 8'h00;
    #1;
    chk(tag, rd_data_o, exp_byte(m_vis, lj, a));
    @(posedge clk_i);
    blk = (rd && !a) || (m_hold && !(rd && a));
    if (blk) begin
      if (cd) begin m_pend.delete(); m_pend.push_back(cv); end
    end else begin
      if (cd) m_vis = cv;
      else if (m_pend.size() > 0) m_vis = m_pend[0];
      m_pend.delete();
    end
    if (rd && a) m_hold = 0;
    else if (rd && !a) m_hold = 1;
    @(negedge clk_i);
  endtask

  initial begin
    #(200_000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset
    step("R1", 0, 0, 0, 0, 0); step("R1", 0, 0, 0, 1, 0);
    step("R1", 0, 0, 0, 0, 1); step("R1", 0, 0, 0, 1, 1);
    // R4 + R2
    step("R4", 1, 'h2A5, 0, 0, 0);
    step("R2", 0, 0, 0, 0, 0); step("R2", 0, 0, 0, 1, 0);
    // R3
    step("R3", 0, 0, 0, 1, 1); step("R3", 0, 0, 0, 0, 1);
    // R6 high-only reads keep updating
    step("R6", 1, 'h3C1, 1, 1, 1);
    step("R6", 1, 'h155, 1, 1, 1);
    step("R6", 0, 0, 1, 1, 1);
    step("R6", 1, 'h0FF, 0, 1, 1);
    step("R6", 0, 0, 0, 0, 0);
    // R5/R7: freeze, two conversions, release
    step("R5", 0, 0, 1, 0, 0);
    step("R7", 1, 'h111, 0, 0, 0);
    step("R7", 1, 'h222, 0, 1, 0);
    step("R5", 0, 0, 0, 0, 0);
    step("R5", 0, 0, 1, 1, 0);
    step("R7", 0, 0, 0, 0, 0); step("R7", 0, 0, 0, 1, 0);
    // R10 collision with low read
    step("R10", 1, 'h3AB, 1, 0, 0);
    step("R10", 0, 0, 0, 0, 0);
    step("R10", 0, 0, 1, 1, 0);
    step("R10", 0, 0, 0, 0, 0);
    // R7 precedence of same-cycle conversion at high read
    step("R7", 0, 0, 1, 0, 1);
    step("R7", 1, 'h001, 0, 0, 1);
    step("R7", 1, 'h3FE, 1, 1, 1);
    step("R7", 0, 0, 0, 1, 1); step("R7", 0, 0, 0, 0, 1);
    // R8 justification toggles
    step("R8", 0, 0, 0, 1, 0); step("R8", 0, 0, 0, 1, 1);
    step("R8", 0, 0, 0, 0, 0); step("R8", 0, 0, 0, 0, 1);
    // R9 writes
    step("R9", 0, 0, 0, 0, 0, 1); step("R9", 0, 0, 0, 1, 0, 1);
    step("R9", 0, 0, 0, 0, 0); step("R9", 0, 0, 0, 1, 0);
    // random mix
    for (int i = 0; i < 400; i++)
      step("R5", 1'($urandom), int'($urandom % 1024), 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom));
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule